// File: doc/BRIEF.md
# Branch Target Lookup Table

This block is a small, fully associative table placed in a processor's fetch stage. Each slot holds an instruction-address tag, a branch target address and a 2-bit hint whose upper bit is the taken/not-taken prediction. Every cycle the fetch address is compared against all valid tags. The matching slot's target and prediction appear on registered outputs one clock later, together with a hit flag.

A single update port writes a tag, a target and a hint. The update first searches the stored tags. If the tag is already present, that slot is rewritten in place. Otherwise a round-robin replacement pointer chooses the slot to overwrite, and the pointer then moves on. A lookup and an update in the same cycle do not interact: the lookup sees the table as it stood before the write.

Top module: `branch_target_table`

## Requirements
- R1: With default parameters the table has 16 slots, each holding a 12-bit tag, a 16-bit target and a 2-bit hint. While reset (rst_n low) is applied, every slot is marked invalid and hit_q, pred_q and target_q read 0.
- R2: A lookup presented on lk_addr before a rising edge is reported after that edge: hit_q=1 and target_q equals the stored target of the matching valid slot.
- R3: When no valid tag equals lk_addr, the registered result is hit_q=0, pred_q=0 (not taken) and target_q=0.
- R4: Slots that are invalid never match, including those whose cleared tag equals the lookup address.
- R5: An update whose tag is already stored rewrites that slot's target and hint, and creates no second copy of the tag.
- R6: An update that rewrites an existing slot leaves the replacement pointer where it was.
- R7: An update with a new tag writes the slot indexed by the replacement pointer, which starts at 0 after reset, advances by one per new allocation and wraps from 15 to 0. Slots are therefore evicted in allocation order.
- R8: pred_q is bit 1 of the stored 2-bit hint. Bit 0 has no effect on the outputs.
- R9: When an update and a lookup occur in the same cycle, the lookup returns the contents the table held before that update.
- R10: The tag search covers every index from the highest (15) down to 0, for both lookups and updates. If several valid slots match, the lowest index is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_addr | input | TAG_W | Fetch address to look up |
| upd_en | input | 1 | Write an entry this cycle |
| upd_tag | input | TAG_W | Tag to write |
| upd_target | input | TGT_W | Branch target to write |
| upd_hint | input | 2 | Hint to write; bit 1 is the prediction |
| hit_q | output | 1 | Registered lookup hit |
| target_q | output | TGT_W | Registered target, 0 on a miss |
| pred_q | output | 1 | Registered prediction, 0 on a miss |

## Verification
Lookups are tried with three kinds of address. Every slot is probed, including index 15, so a search that skips the top of the range or returns the wrong slot is caught. Unknown addresses and a just-reset table are also probed; these show whether misses and invalid slots stay silent. Update sequences separate rewriting a slot in place from allocating a new one. A run that fills the table, rewrites one tag and then allocates again shows whether the pointer stood still or moved, and whether a duplicate survived the next eviction. Same-cycle update and lookup of one address distinguish old-contents forwarding from new-contents forwarding.

// File: rtl/btt_pkg.sv
package btt_pkg;
    localparam int HINT_W   = 2;
    localparam int PRED_BIT = 1;
    typedef logic [HINT_W-1:0] hint_t;
endpackage

// File: rtl/btt_tag_match.sv
module btt_tag_match #(
    parameter int N     = 16,
    parameter int TAG_W = 12
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]        key_i,
    output logic [N-1:0]            match_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end
endmodule

// File: rtl/btt_first_hit.sv
module btt_first_hit #(
    parameter int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     grant_o
);
    // Scan from the top index down to 0 so the lowest match is the last written.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                grant_o = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    always_comb begin
        assert_onehot_grant_R10: assert ($onehot0(grant_o));
        assert_found_any_R10: assert (found_o == (|req_i));
    end
endmodule

// File: rtl/branch_target_table.sv
module branch_target_table
    import btt_pkg::*;
#(
    parameter int N     = 16,
    parameter int TAG_W = 12,
    parameter int TGT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_addr,
    input  logic             upd_en,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [TGT_W-1:0] upd_target,
    input  logic [HINT_W-1:0] upd_hint,
    output logic             hit_q,
    output logic [TGT_W-1:0] target_q,
    output logic             pred_q
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0][TAG_W-1:0] tag;
        logic [N-1:0][TGT_W-1:0] tgt;
        logic [N-1:0][HINT_W-1:0] hint;
        logic [IDX_W-1:0]        ptr;
        logic                    hit;
        logic [TGT_W-1:0]        tgt_out;
        logic                    pred;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]     lk_match, up_match, lk_grant, up_grant;
    logic             lk_found, up_found;
    logic [IDX_W-1:0] lk_idx, up_idx, wr_idx;

    btt_tag_match #(.N(N), .TAG_W(TAG_W)) u_lk_match (
        .valid_i(st_q.valid), .tags_i(st_q.tag), .key_i(lk_addr), .match_o(lk_match)
    );
    btt_tag_match #(.N(N), .TAG_W(TAG_W)) u_up_match (
        .valid_i(st_q.valid), .tags_i(st_q.tag), .key_i(upd_tag), .match_o(up_match)
    );
    btt_first_hit #(.N(N)) u_lk_pick (
        .req_i(lk_match), .found_o(lk_found), .idx_o(lk_idx), .grant_o(lk_grant)
    );
    btt_first_hit #(.N(N)) u_up_pick (
        .req_i(up_match), .found_o(up_found), .idx_o(up_idx), .grant_o(up_grant)
    );

    always_comb begin
        st_d = st_q;
        // Lookup reads the pre-update contents.
        st_d.hit     = lk_found;
        st_d.tgt_out = lk_found ? st_q.tgt[lk_idx] : '0;
        st_d.pred    = lk_found && st_q.hint[lk_idx][PRED_BIT];
        wr_idx = up_found ? up_idx : st_q.ptr;
        if (upd_en) begin
            st_d.valid[wr_idx] = 1'b1;
            st_d.tag[wr_idx]   = upd_tag;
            st_d.tgt[wr_idx]   = upd_target;
            st_d.hint[wr_idx]  = upd_hint;
            if (!up_found) begin
                st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_q    = st_q.hit;
    assign target_q = st_q.tgt_out;
    assign pred_q   = st_q.pred;

    assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_q |-> (!pred_q && target_q == '0));

    assert_hit_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(|st_q.valid));

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && up_found) |=> $stable(st_q.ptr));

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !up_found) |=>
            (st_q.ptr == (($past(st_q.ptr) == LAST) ? '0 : $past(st_q.ptr) + 1'b1)));

    assert_valid_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(st_q.valid) <= $countones($past(st_q.valid)) + 1));

    assert_no_change_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> ($stable(st_q.valid) && $stable(st_q.ptr)));
endmodule

// File: tb/branch_target_table_bench.sv
module branch_target_table_bench;
    localparam int TAG_W = 12;
    localparam int TGT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TAG_W-1:0] lk_addr = '0;
    logic             upd_en = 1'b0;
    logic [TAG_W-1:0] upd_tag = '0;
    logic [TGT_W-1:0] upd_target = '0;
    logic [1:0]       upd_hint = '0;
    logic             hit_q;
    logic [TGT_W-1:0] target_q;
    logic             pred_q;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    branch_target_table u_branch_target_table (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .upd_en(upd_en),
        .upd_tag(upd_tag), .upd_target(upd_target), .upd_hint(upd_hint),
        .hit_q(hit_q), .target_q(target_q), .pred_q(pred_q)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [TAG_W-1:0] t, input logic [TGT_W-1:0] d, input logic [1:0] h);
        upd_en = 1'b1; upd_tag = t; upd_target = d; upd_hint = h;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic expect_lookup(input logic [TAG_W-1:0] a, input bit eh,
                                 input logic [TGT_W-1:0] et, input bit ep, input string req);
        lk_addr = a;
        @(negedge clk);
        check(hit_q == eh, {req, " hit"}, hit_q, eh);
        check(target_q == et, {req, " target"}, target_q, et);
        check(pred_q == ep, {req, " pred"}, pred_q, ep);
    endtask

    task automatic test_reset_state();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(hit_q == 1'b0 && pred_q == 1'b0 && target_q == '0, "R1 reset outputs",
              {hit_q, pred_q, target_q}, 0);
        rst_n = 1'b1;
        expect_lookup(12'h000, 1'b0, '0, 1'b0, "R4 cleared tag");
    endtask

    task automatic test_fill_and_probe();
        do_reset();
        for (int i = 0; i < 16; i++) begin
            do_write(12'h100 + 12'(i), 16'hA000 + 16'(i), (i % 2 == 0) ? 2'b10 : 2'b01);
        end
        for (int i = 15; i >= 0; i--) begin
            expect_lookup(12'h100 + 12'(i), 1'b1, 16'hA000 + 16'(i), (i % 2 == 0),
                          (i == 15) ? "R10 top slot" : "R2 R8 slot");
        end
        expect_lookup(12'h0FF, 1'b0, '0, 1'b0, "R3 unknown addr");
    endtask

    task automatic test_replace_order();
        do_write(12'h200, 16'hB200, 2'b10);
        expect_lookup(12'h100, 1'b0, '0, 1'b0, "R7 wrap evicts slot0");
        expect_lookup(12'h200, 1'b1, 16'hB200, 1'b1, "R7 new entry");
        do_write(12'h10F, 16'hBEEF, 2'b11);
        expect_lookup(12'h10F, 1'b1, 16'hBEEF, 1'b1, "R5 R10 rewrite top slot");
        do_write(12'h201, 16'hB201, 2'b00);
        expect_lookup(12'h101, 1'b0, '0, 1'b0, "R6 slot1 evicted");
        expect_lookup(12'h102, 1'b1, 16'hA002, 1'b1, "R6 slot2 kept");
        expect_lookup(12'h201, 1'b1, 16'hB201, 1'b0, "R8 hint bit0 ignored");
    endtask

    task automatic test_same_cycle();
        lk_addr = 12'h300;
        do_write(12'h300, 16'hC300, 2'b10);
        check(hit_q == 1'b0, "R9 new tag old view hit", hit_q, 0);
        check(target_q == '0, "R9 new tag old view target", target_q, 0);
        expect_lookup(12'h300, 1'b1, 16'hC300, 1'b1, "R9 after write");
        lk_addr = 12'h200;
        do_write(12'h200, 16'hCAFE, 2'b00);
        check(target_q == 16'hB200, "R9 rewrite old target", target_q, 16'hB200);
        check(pred_q == 1'b1, "R9 rewrite old pred", pred_q, 1);
        expect_lookup(12'h200, 1'b1, 16'hCAFE, 1'b0, "R9 rewrite new");
    endtask

    task automatic test_no_duplicate();
        do_reset();
        do_write(12'h050, 16'h1111, 2'b10);
        do_write(12'h050, 16'h2222, 2'b10);
        for (int i = 1; i <= 15; i++) begin
            do_write(12'h400 + 12'(i), 16'h4000 + 16'(i), 2'b00);
        end
        expect_lookup(12'h050, 1'b1, 16'h2222, 1'b1, "R5 kept in place");
        do_write(12'h4FF, 16'h4FFF, 2'b00);
        expect_lookup(12'h050, 1'b0, '0, 1'b0, "R5 R7 no duplicate left");
        expect_lookup(12'h401, 1'b1, 16'h4001, 1'b0, "R7 slot1 kept");
        do_reset();
        expect_lookup(12'h4FF, 1'b0, '0, 1'b0, "R1 R4 reset invalidates");
    endtask

    initial begin
        test_reset_state();
        test_fill_and_probe();
        test_replace_order();
        test_same_cycle();
        test_no_duplicate();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule